// File: doc/BRIEF.md
# Master Status and Interrupt Aggregator

This block gathers event and alarm indications from a set of sub-blocks into one 16-bit master status word. Host software reads that word first, finds out which sub-block needs attention, and services only that one. Single-cycle event pulses from the sub-blocks are latched until the host reads them. Level alarms are shown live. A small group of flags can be set and cleared by software. Two event sources live inside the block. The first is a one-second boundary tick, made by dividing the host reference clock. The second is an overflow event, raised when the OR of the saturation flags from external error counters goes from low to high.

A synchronous register port reaches two words: the master status word and a per-bit interrupt mask. Read data is registered. A read of the status word clears every latched event bit. A single active-high interrupt output is raised while any latched bit or software flag is set and its mask bit is one.

Top module: `msr_aggregator`

## Requirements
- R1: Status word layout at address 0x08: bit 0 one-second tick, bit 1 counter overflow, bits 2..6 sub-block events evt_i[0..4], bits 8..10 live alarms alarm_i[0..2], bits 11..14 software flags. Bits 7 and 15 always read as zero. The mask word is at address 0x0A. A read returns its data on rdata one cycle after rd_en, and rdata holds that value until the next read.
- R2: A one-cycle pulse on evt_i[k] sets status bit 2+k on the next clock. The bit stays set until the status word is read.
- R3: A read of the status word returns the value from before the read. In the following cycle, latched bits 0..6 are cleared.
- R4: An event that arrives in the same cycle as a status read is not lost. Its bit is set after the read, even though the value returned did not include it.
- R5: Bit 1 is set once on each rising edge of the OR of all sat_i flags. A read clears it even while a counter stays saturated. A flag that stays saturated does not set it again.
- R6: Bit 0 is set once every CLK_HZ clock cycles, from a free-running divider that starts counting when reset ends.
- R7: A write to the status word does not change bits 0..10.
- R8: A write to the status word loads bits 11..14 from wdata. Reads do not clear these bits.
- R9: Bits 0..6 and 8..14 of the mask word can be read and written. Mask bits 7 and 15 read as zero.
- R10: irq is high one cycle after any of status bits 0..6 or 11..14 is set while its mask bit is one. The alarm bits 8..10 never raise irq.
- R11: irq goes low in the cycle after a clearing read has removed the last masked latched bit.
- R12: Alarm bits 8..10 follow alarm_i as sampled in the read cycle and are never latched.
- R13: Synchronous reset clears the status, the mask, rdata and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| evt_i | input | 5 | Sub-block event pulses |
| sat_i | input | N_SAT | Error counter saturation flags |
| alarm_i | input | 3 | Sub-block level alarms |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench looks for lost occurrences. It fires an event in the same cycle as a status read. A design that clears unconditionally would then drop the event, and the second read would show zero. The bench holds a counter flag saturated across a clearing read. A level-triggered overflow would set bit 1 again, and a design that waits for the flag to drop would never clear it. The bench writes all ones to the status word to catch read-only bits that can be written. It measures the spacing between interrupt rises with only the tick unmasked. An off-by-one divider shows up as CLK_HZ plus or minus one. It also checks the cycle in which irq rises and falls, which exposes a missing or extra register stage.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned N_EVT    = 5;
  localparam int unsigned N_LVL    = 3;
  localparam int unsigned N_SW     = 4;
  localparam int unsigned BIT_TICK = 0;
  localparam int unsigned BIT_OVF  = 1;
  localparam int unsigned EVT_LSB  = 2;
  localparam int unsigned LVL_LSB  = 8;
  localparam int unsigned SW_LSB   = 11;

  typedef logic [REG_W-1:0] word_t;

  function automatic word_t field_mask(int unsigned lsb, int unsigned n);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam word_t LATCH_M = field_mask(0, EVT_LSB + N_EVT);
  localparam word_t LVL_M   = field_mask(LVL_LSB, N_LVL);
  localparam word_t SW_M    = field_mask(SW_LSB, N_SW);
  localparam word_t USED_M  = LATCH_M | LVL_M | SW_M;
  localparam word_t INT_M   = LATCH_M | SW_M;
endpackage

// File: rtl/msr_sec_timer.sv
module msr_sec_timer #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= RELOAD;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == '0);
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // Independent gap counter used only to check the tick spacing.
  logic [CNT_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_tick_period_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_o && seen_q) |-> (gap_q == RELOAD))
    else $error("R6 tick spacing differs from CLK_HZ");
endmodule

// File: rtl/msr_sat_edge.sv
module msr_sat_edge #(
  parameter int unsigned N_SAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SAT-1:0] sat_i,
  output logic             ovf_o
);
  logic any_q;
  logic any_now;

  assign any_now = |sat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      any_q <= any_now;
      ovf_o <= any_now & ~any_q;
    end
  end

  p_ovf_single_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o)
    else $error("R5 overflow pulse longer than one cycle");
endmodule

// File: rtl/msr_status_core.sv
module msr_status_core
  import msr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  word_t             set_vec,
  input  word_t             lvl_vec,
  output word_t             status_o,
  output word_t             mask_o,
  output word_t             rdata_o
);
  word_t latch_q, sw_q, mask_q;
  logic  stat_rd, stat_wr, mask_rd, mask_wr;

  assign stat_rd = rd_en && (addr == STAT_ADDR);
  assign stat_wr = wr_en && (addr == STAT_ADDR);
  assign mask_rd = rd_en && (addr == MASK_ADDR);
  assign mask_wr = wr_en && (addr == MASK_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      sw_q    <= '0;
      mask_q  <= '0;
      rdata_o <= '0;
    end else begin
      latch_q <= ((stat_rd ? '0 : latch_q) | set_vec) & LATCH_M;
      if (stat_wr) sw_q   <= wdata & SW_M;
      if (mask_wr) mask_q <= wdata & USED_M;
      if (rd_en) begin
        if (stat_rd)      rdata_o <= (latch_q | sw_q | lvl_vec) & USED_M;
        else if (mask_rd) rdata_o <= mask_q;
        else              rdata_o <= '0;
      end
    end
  end

  assign status_o = latch_q | sw_q;
  assign mask_o   = mask_q;

  p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & LATCH_M) != '0) |=>
      ((latch_q & $past(set_vec & LATCH_M)) == $past(set_vec & LATCH_M)))
    else $error("R2 event not latched");

  p_clr_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && ((set_vec & LATCH_M) == '0)) |=> (latch_q == '0))
    else $error("R3 latched bits survive a read");

  p_keep_same_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && ((set_vec & LATCH_M) != '0)) |=>
      ((latch_q & $past(set_vec & LATCH_M)) != '0))
    else $error("R4 same-cycle event lost");

  p_ro_ignore_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && ((set_vec & LATCH_M) == '0)) |=>
      ((latch_q & ~$past(latch_q)) == '0))
    else $error("R7 write changed a read-only bit");

  p_sw_write_r8: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (sw_q == ($past(wdata) & SW_M)))
    else $error("R8 software flags not loaded");
endmodule

// File: rtl/msr_irq_gen.sv
module msr_irq_gen
  import msr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t status_i,
  input  word_t mask_i,
  output logic  irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & mask_i & INT_M);
  end

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    ((status_i & mask_i & INT_M) == '0) |=> !irq_o)
    else $error("R10 irq without a masked status bit");
endmodule

// File: rtl/msr_aggregator.sv
module msr_aggregator
  import msr_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned N_SAT     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [4:0]        evt_i,
  input  logic [N_SAT-1:0]  sat_i,
  input  logic [2:0]        alarm_i,
  output logic              irq
);
  logic  tick, ovf;
  word_t set_vec, lvl_vec, status, mask;

  msr_sec_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  msr_sat_edge #(.N_SAT(N_SAT)) u_sat (
    .clk(clk), .rst(rst), .sat_i(sat_i), .ovf_o(ovf)
  );

  always_comb begin
    set_vec = '0;
    set_vec[BIT_TICK] = tick;
    set_vec[BIT_OVF]  = ovf;
    set_vec[EVT_LSB +: N_EVT] = evt_i;
    lvl_vec = '0;
    lvl_vec[LVL_LSB +: N_LVL] = alarm_i;
  end

  msr_status_core #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_core (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .set_vec(set_vec), .lvl_vec(lvl_vec),
    .status_o(status), .mask_o(mask), .rdata_o(rdata)
  );

  msr_irq_gen u_irq (
    .clk(clk), .rst(rst), .status_i(status), .mask_i(mask), .irq_o(irq)
  );

  p_ovf_from_edge_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_OVF]) |-> $past(|sat_i, 2))
    else $error("R5 overflow bit set without a saturation edge");
endmodule

// File: tb/tb_msr_aggregator.sv
module tb_msr_aggregator;
  localparam int unsigned HZ = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  evt_i = '0;
  logic [3:0]  sat_i = '0;
  logic [2:0]  alarm_i = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  msr_aggregator #(.CLK_HZ(HZ), .N_SAT(4), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .sat_i(sat_i),
    .alarm_i(alarm_i), .irq(irq)
  );

  typedef struct packed {
    logic [4:0]  evt;
    logic [3:0]  sat;
    logic [2:0]  lvl;
    logic [15:0] exp;
  } vec_t;

  // Read-back expectations exclude bit 0 (the tick), which is checked on its own.
  localparam vec_t VECS [12] = '{
    '{5'b00000, 4'b0000, 3'b000, 16'h0000},
    '{5'b00001, 4'b0000, 3'b000, 16'h0004},
    '{5'b10100, 4'b0000, 3'b000, 16'h0050},
    '{5'b00000, 4'b0010, 3'b000, 16'h0002},
    '{5'b00000, 4'b0010, 3'b000, 16'h0000},
    '{5'b00000, 4'b0110, 3'b000, 16'h0000},
    '{5'b00000, 4'b0000, 3'b000, 16'h0000},
    '{5'b00000, 4'b1000, 3'b000, 16'h0002},
    '{5'b00000, 4'b1000, 3'b101, 16'h0500},
    '{5'b11111, 4'b1000, 3'b010, 16'h027C},
    '{5'b00000, 4'b0000, 3'b000, 16'h0000},
    '{5'b01000, 4'b0001, 3'b000, 16'h0022}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0000, 16'h0001);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13 reset state
    check("R13 irq after reset", {15'b0, irq}, 16'h0000);
    check("R13 rdata after reset", rdata, 16'h0000);
    do_read(8'h0A, d);
    check("R13 mask after reset", d, 16'h0000);
    do_read(8'h08, d);
    check("R13 status after reset", d & 16'hFFFE, 16'h0000);

    // Vector table: R1 R2 R3 R5 R12
    foreach (VECS[i]) begin
      sat_i = VECS[i].sat;
      alarm_i = VECS[i].lvl;
      pulse(VECS[i].evt);
      @(negedge clk);
      do_read(8'h08, d);
      check($sformatf("R2/R3/R5/R12 vector %0d", i), d & 16'hFFFE, VECS[i].exp);
    end
    sat_i = '0; alarm_i = '0;
    @(negedge clk);
    do_read(8'h08, d);

    // R4 event in the same cycle as a status read
    evt_i = 5'b00001; rd_en = 1'b1; addr = 8'h08;
    @(negedge clk);
    evt_i = '0; rd_en = 1'b0;
    check("R4 read value excludes same-cycle event", rdata & 16'h0004, 16'h0000);
    do_read(8'h08, d);
    check("R4 same-cycle event kept", d & 16'hFFFE, 16'h0004);

    // R7 R8 writes to status
    do_write(8'h08, 16'hFFFF);
    do_read(8'h08, d);
    check("R7/R8 write all ones", d & 16'hFFFE, 16'h7800);
    do_read(8'h08, d);
    check("R8 flags survive read", d & 16'hFFFE, 16'h7800);
    do_write(8'h08, 16'h0000);
    do_read(8'h08, d);
    check("R8 flags cleared by write", d & 16'hFFFE, 16'h0000);

    // R9 mask register
    do_write(8'h0A, 16'hFFFF);
    do_read(8'h0A, d);
    check("R9 mask readback", d, 16'h7F7F);

    // R10 R11 interrupt timing
    do_write(8'h0A, 16'h0004);
    pulse(5'b00001);
    check("R10 irq not yet", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    check("R10 irq raised", {15'b0, irq}, 16'h0001);
    do_read(8'h08, d);
    check("R10 status shows source", d & 16'h0004, 16'h0004);
    check("R11 irq held until clear lands", {15'b0, irq}, 16'h0001);
    @(negedge clk);
    check("R11 irq released", {15'b0, irq}, 16'h0000);

    // R10 unmasked source gives no irq
    pulse(5'b00010);
    repeat (2) @(negedge clk);
    check("R10 masked-off event", {15'b0, irq}, 16'h0000);
    do_read(8'h08, d);

    // R12 alarms never interrupt
    do_write(8'h0A, 16'h0700);
    alarm_i = 3'b111;
    repeat (3) @(negedge clk);
    check("R12 alarm no irq", {15'b0, irq}, 16'h0000);
    do_read(8'h08, d);
    check("R12 alarm live", d & 16'hFFFE, 16'h0700);
    alarm_i = '0;

    // R10 software flag interrupt
    do_write(8'h0A, 16'h0800);
    do_write(8'h08, 16'h0800);
    @(negedge clk);
    check("R10 flag irq", {15'b0, irq}, 16'h0001);
    do_write(8'h08, 16'h0000);
    @(negedge clk);
    check("R10 flag irq gone", {15'b0, irq}, 16'h0000);

    // R6 tick spacing
    do_write(8'h0A, 16'h0001);
    do_read(8'h08, d);
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    rd_en = 1'b1; addr = 8'h08;
    @(negedge clk);
    rd_en = 1'b0;
    check("R6 tick bit set", rdata & 16'h0001, 16'h0001);
    n = 1;
    while (irq && n < 1000) begin @(negedge clk); n++; end
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    check("R6 tick period", 16'(n), 16'(HZ));

    finish_run();
  end
endmodule